// File: doc/BRIEF.md
# Push-Button Tone Parameter Controller

This block sits between a panel of five already-debounced push buttons, a bank of slide switches and a direct digital synthesis core. It holds the three settings the core reads: a phase increment that sets the output frequency, an amplitude coefficient that scales the samples, and a bit that picks one of two stored waveforms.

Each button acts on the cycle its level first goes high. The switch bank supplies an unsigned step size. The right and left buttons move the phase increment up or down by that step. The up and down buttons do the same for the amplitude. The center button flips the waveform bit. A button that stays pressed does nothing more until it has been released and pressed again. Both numeric settings stop at zero and at their all-ones maximum instead of wrapping. When several buttons go high in the same cycle, only the highest-priority one takes effect.

After reset the phase increment is 601, which gives about 440 Hz at a 48 kHz update rate with a 16-bit phase accumulator. The amplitude is 256, which is unity gain in a format with 8 fractional bits. The waveform bit is 0.

Top module: `tone_param_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, phase_inc_o is 601, amp_o is 256 and wave_sel_o is 0.
- R2: A rising edge on btn_right_i adds step_i to phase_inc_o. The new value is visible after the same clock edge that samples the high level.
- R3: A rising edge on btn_left_i subtracts step_i from phase_inc_o, with the same timing as R2.
- R4: A rising edge on btn_up_i adds step_i to amp_o, with the same timing as R2.
- R5: A rising edge on btn_down_i subtracts step_i from amp_o, with the same timing as R2.
- R6: A rising edge on btn_center_i inverts wave_sel_o, with the same timing as R2.
- R7: A button held high for any number of cycles, and its release, cause no change beyond the single action of its rising edge. No more than one of the three outputs changes in any cycle.
- R8: Additions saturate at the all-ones maximum: 4095 for phase_inc_o (12 bits) and 1023 for amp_o (10 bits). Subtractions saturate at 0. Neither register wraps.
- R9: When several buttons rise in the same cycle, only one acts, chosen in the order right, left, up, down, center. The other rising edges are discarded and need a fresh press.
- R10: A press with step_i equal to 0 on right, left, up or down leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_left_i | input | 1 | Debounced level: lower the frequency |
| btn_right_i | input | 1 | Debounced level: raise the frequency |
| btn_up_i | input | 1 | Debounced level: raise the amplitude |
| btn_down_i | input | 1 | Debounced level: lower the amplitude |
| btn_center_i | input | 1 | Debounced level: swap the waveform |
| step_i | input | 8 | Unsigned step size from the switches |
| phase_inc_o | output | 12 | Phase increment for the accumulator |
| amp_o | output | 10 | Amplitude coefficient |
| wave_sel_o | output | 1 | Waveform select |

## Verification
The assertions assume the button inputs are synchronous to clk_i and free of bounce, so that each level change is one intended press. They also assume step_i is stable in any cycle where a button rises. The bench meets both conditions by changing buttons and switches only on the falling clock edge, and by holding each press for several cycles before releasing it.

The bench sweeps every step value on all four numeric buttons. It drives each register into both saturation limits, then issues a long pseudo-random series of single and multiple simultaneous presses. The expected values come from an arithmetic model that clamps results to the limits.

// File: rtl/tone_ctrl_pkg.sv
package tone_ctrl_pkg;
  localparam int NUM_BTN = 5;
  // bit positions inside the rise vector; lower index = higher priority
  localparam int B_RIGHT  = 0;
  localparam int B_LEFT   = 1;
  localparam int B_UP     = 2;
  localparam int B_DOWN   = 3;
  localparam int B_CENTER = 4;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FREQ_UP,
    ACT_FREQ_DN,
    ACT_AMP_UP,
    ACT_AMP_DN,
    ACT_WAVE
  } act_e;
endpackage

// File: rtl/press_detect.sv
module press_detect #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R7: a press cannot be seen twice in a row
    p_single_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/action_arbiter.sv
module action_arbiter
  import tone_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] rise_i,
  output act_e               act_o
);
  always_comb begin
    act_o = ACT_NONE;
    if      (rise_i[B_RIGHT])  act_o = ACT_FREQ_UP;
    else if (rise_i[B_LEFT])   act_o = ACT_FREQ_DN;
    else if (rise_i[B_UP])     act_o = ACT_AMP_UP;
    else if (rise_i[B_DOWN])   act_o = ACT_AMP_DN;
    else if (rise_i[B_CENTER]) act_o = ACT_WAVE;
  end

  p_right_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i[B_RIGHT] |-> act_o == ACT_FREQ_UP);
  p_center_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o == ACT_WAVE) |-> $countones(rise_i) == 1);
endmodule

// File: rtl/sat_step_reg.sv
module sat_step_reg #(
  parameter int W       = 12,
  parameter int SW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic [SW-1:0] step_i,
  output logic [W-1:0]  q_o
);
  localparam logic [W:0] MAX_EXT = {1'b0, {W{1'b1}}};

  logic [W:0]   step_ext, sum;
  logic [W-1:0] nxt;

  assign step_ext = {{(W + 1 - SW){1'b0}}, step_i};
  assign sum      = {1'b0, q_o} + step_ext;

  always_comb begin
    nxt = q_o;
    if (inc_i)      nxt = (sum > MAX_EXT) ? {W{1'b1}} : sum[W-1:0];
    else if (dec_i) nxt = (step_ext > {1'b0, q_o}) ? '0 : q_o - step_ext[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= W'(RST_VAL);
    else         q_o <= nxt;
  end

  p_no_wrap_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> q_o >= $past(q_o));
  p_no_wrap_dn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> q_o <= $past(q_o));
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(q_o));
endmodule

// File: rtl/tone_param_ctrl.sv
module tone_param_ctrl
  import tone_ctrl_pkg::*;
#(
  parameter int PINC_W   = 12,
  parameter int AMP_W    = 10,
  parameter int STEP_W   = 8,
  parameter int PINC_RST = 601,
  parameter int AMP_RST  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              btn_left_i,
  input  logic              btn_right_i,
  input  logic              btn_up_i,
  input  logic              btn_down_i,
  input  logic              btn_center_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [PINC_W-1:0] phase_inc_o,
  output logic [AMP_W-1:0]  amp_o,
  output logic              wave_sel_o
);
  logic [NUM_BTN-1:0] lvl, rise;
  act_e               act;

  always_comb begin
    lvl           = '0;
    lvl[B_RIGHT]  = btn_right_i;
    lvl[B_LEFT]   = btn_left_i;
    lvl[B_UP]     = btn_up_i;
    lvl[B_DOWN]   = btn_down_i;
    lvl[B_CENTER] = btn_center_i;
  end

  press_detect #(.N(NUM_BTN)) u_detect (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .rise_o(rise)
  );

  action_arbiter u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .act_o(act)
  );

  sat_step_reg #(.W(PINC_W), .SW(STEP_W), .RST_VAL(PINC_RST)) u_pinc (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .inc_i (act == ACT_FREQ_UP), .dec_i(act == ACT_FREQ_DN),
    .step_i(step_i), .q_o(phase_inc_o)
  );

  sat_step_reg #(.W(AMP_W), .SW(STEP_W), .RST_VAL(AMP_RST)) u_amp (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .inc_i (act == ACT_AMP_UP), .dec_i(act == ACT_AMP_DN),
    .step_i(step_i), .q_o(amp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wave_sel_o <= 1'b0;
    else if (act == ACT_WAVE) wave_sel_o <= ~wave_sel_o;
  end

  p_one_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({phase_inc_o != $past(phase_inc_o), amp_o != $past(amp_o),
                wave_sel_o != $past(wave_sel_o)}) <= 1);
  p_center_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_center_i && !$past(btn_center_i) && !btn_right_i && !btn_left_i &&
     !btn_up_i && !btn_down_i) |=> wave_sel_o != $past(wave_sel_o));
  p_zero_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0 && !btn_center_i) |=> $stable(phase_inc_o) && $stable(amp_o));
endmodule

// File: tb/tone_param_ctrl_test.sv
module tone_param_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PMAX = 4095;
  localparam int AMAX = 1023;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       b_left = 0, b_right = 0, b_up = 0, b_down = 0, b_center = 0;
  logic [7:0] step = '0;
  logic [11:0] pinc;
  logic [9:0]  amp;
  logic        wsel;

  int checks = 0, errors = 0;
  int m_pinc = 601, m_amp = 256;
  bit m_wave = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tone_param_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .btn_left_i(b_left), .btn_right_i(b_right), .btn_up_i(b_up),
    .btn_down_i(b_down), .btn_center_i(b_center), .step_i(step),
    .phase_inc_o(pinc), .amp_o(amp), .wave_sel_o(wsel)
  );

  task automatic check(input string req);
    checks++;
    if (int'(pinc) != m_pinc || int'(amp) != m_amp || wsel != m_wave) begin
      errors++;
      $display("FAIL %s: got pinc=%0d amp=%0d wave=%0d, expected pinc=%0d amp=%0d wave=%0d",
               req, pinc, amp, wsel, m_pinc, m_amp, m_wave);
    end
  endtask

  // mask bits: 0 right, 1 left, 2 up, 3 down, 4 center
  task automatic press(input logic [4:0] mask, input int s);
    string tag;
    if ($countones(mask) > 1)                  tag = "R9";
    else if (mask[4])                          tag = "R6";
    else if (s == 0)                           tag = "R10";
    else if (mask[0]) tag = (m_pinc + s > PMAX) ? "R8" : "R2";
    else if (mask[1]) tag = (s > m_pinc)        ? "R8" : "R3";
    else if (mask[2]) tag = (m_amp + s > AMAX)  ? "R8" : "R4";
    else              tag = (s > m_amp)         ? "R8" : "R5";
    @(negedge clk);
    step = 8'(s);
    {b_center, b_down, b_up, b_left, b_right} = mask;
    if      (mask[0]) m_pinc = (m_pinc + s > PMAX) ? PMAX : m_pinc + s;
    else if (mask[1]) m_pinc = (s > m_pinc) ? 0 : m_pinc - s;
    else if (mask[2]) m_amp  = (m_amp + s > AMAX) ? AMAX : m_amp + s;
    else if (mask[3]) m_amp  = (s > m_amp) ? 0 : m_amp - s;
    else if (mask[4]) m_wave = ~m_wave;
    @(negedge clk);
    check(tag);
    repeat (2) @(negedge clk);
    check("R7 held");
    {b_center, b_down, b_up, b_left, b_right} = '0;
    @(negedge clk);
    check("R7 released");
  endtask

  initial begin
    int lcg = 12345;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    for (int s = 0; s < 256; s++) begin
      press(5'b00001, s);
      press(5'b00010, s);
      press(5'b00100, s);
      press(5'b01000, s);
    end
    press(5'b10000, 0);
    press(5'b10000, 7);

    for (int i = 0; i < 20; i++) press(5'b00001, 255);
    for (int i = 0; i < 20; i++) press(5'b00010, 255);
    for (int i = 0; i < 6; i++)  press(5'b00100, 255);
    for (int i = 0; i < 6; i++)  press(5'b01000, 255);

    press(5'b11111, 9);
    press(5'b11110, 9);
    press(5'b11100, 9);
    press(5'b11000, 9);

    for (int i = 0; i < 1500; i++) begin
      lcg = lcg * 1103515245 + 12345;
      press(5'((lcg >>> 8) & 31), (lcg >>> 16) & 255);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule